// File: doc/BRIEF.md
# Load Data Formatter and Byte-Lane Unit

This unit sits between the register file and a 32-bit little-endian data memory port. For each access it turns the raw word read from memory into the value a register should receive. It also turns a register value into memory write data with per-byte write strobes. Five access kinds are handled: whole word, byte and halfword, with the narrow loads in zero-extending and sign-extending forms. Address generation, the memory array and any bus handshake stay outside the unit.

Every cycle the unit samples one access description and presents the formatted results one clock later from a single output register stage. A word load from an address that is not a multiple of four is not split and does not fault. It returns the aligned word that contains the addressed byte, rotated so that this byte lands in bits [7:0]. The unit has no state machine. Its only stored state is the output stage, which is either held in reset (all zero) or tracks the previous cycle's access.

Top module: `load_store_lane_fmt`

## Requirements
- R1: Results appear one clock after the access is sampled on the rising edge of `clk`. While `rst_n` is low, `ld_value`, `mem_wdata` and `mem_be` are all zero, and pulling `rst_n` low clears them at once.
- R2: A word load (`acc_size` = 2'b10) returns `mem_rdata` rotated right by 8 × `addr_lo` bits, so the byte at offset `addr_lo` appears in bits [7:0]. With `addr_lo` = 0 the word passes unchanged.
- R3: An unsigned byte load (`acc_size` = 2'b00, `acc_signed` = 0) returns byte `addr_lo` of `mem_rdata` in bits [7:0]. Bits [31:8] are zero. Byte k of the word occupies bits [8k+7:8k].
- R4: A halfword load (`acc_size` = 2'b01) takes bits [15:0] when `addr_lo[1]` is 0 and bits [31:16] when it is 1. `addr_lo[0]` has no effect. The unsigned form zero-pads to 32 bits.
- R5: With `acc_signed` = 1, byte and halfword loads copy the top bit of the loaded item into all higher bits of `ld_value`.
- R6: A byte store (`acc_size` = 2'b00, `acc_store` = 1) raises exactly one strobe, `mem_be[addr_lo]`. It drives the register's bits [7:0] on all four byte lanes of `mem_wdata`.
- R7: A halfword store raises `mem_be` = 4'b0011 when `addr_lo[1]` is 0 and 4'b1100 when it is 1. `mem_wdata` carries the register's bits [15:0] in both halves.
- R8: A word store raises all four strobes and passes the register value to `mem_wdata` unchanged, whatever `addr_lo` is.
- R9: On a load, `mem_be` and `mem_wdata` are zero. On a store, `ld_value` is zero and `mem_rdata` has no effect.
- R10: Size code 2'b11 behaves exactly like a word access, and `acc_signed` has no effect on word accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| acc_signed | input | 1 | Sign-extend narrow loads |
| acc_store | input | 1 | 1 store, 0 load |
| addr_lo | input | 2 | Byte offset of the access within the word |
| mem_rdata | input | 32 | Word read from data memory |
| st_src | input | 32 | Register value to be stored |
| ld_value | output | 32 | Formatted value for the register file |
| mem_wdata | output | 32 | Store data replicated onto the byte lanes |
| mem_be | output | 4 | Per-byte write strobes, bit k for bits [8k+7:8k] |

## Verification
Loads and stores use one shared output register. Two collisions are therefore possible. A store can follow a load, or a load a store, in consecutive cycles: the bench drives its vector table with no idle cycles between entries, so each check also confirms that no strobe or load data from the previous entry remains. Reset can also be asserted while a word store is being presented: the bench lowers `rst_n` between clock edges and requires all outputs to read zero before the next edge. A separate check sets up a new access between two edges and confirms that the outputs still show the previous access, which pins down the one-cycle latency.

// File: rtl/lsl_fmt_pkg.sv
package lsl_fmt_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lsl_load_align.sv
module lsl_load_align
    import lsl_fmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  acc_size_e                          size,
    input  logic                               sgn,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]   ofs,
    input  logic [DATA_W-1:0]                  rdata,
    output logic [DATA_W-1:0]                  result
);
    localparam int LANES  = DATA_W / BYTE_W;
    localparam int OFS_W  = $clog2(LANES);
    localparam int HALF_W = 2 * BYTE_W;

    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] half_shift;
    logic [OFS_W-1:0]  half_ofs;
    logic [BYTE_W-1:0] byte_val;
    logic [HALF_W-1:0] half_val;

    // Rotate right so the addressed byte reaches the bottom lane.
    always_comb begin
        rotated = (rdata >> (int'(ofs) * BYTE_W))
                | (rdata << (DATA_W - int'(ofs) * BYTE_W));
        byte_val = rotated[BYTE_W-1:0];
    end

    // Halfword select ignores the lowest offset bit.
    always_comb begin
        half_ofs   = ofs & ~OFS_W'(1);
        half_shift = rdata >> (int'(half_ofs) * BYTE_W);
        half_val   = half_shift[HALF_W-1:0];
    end

    always_comb begin
        unique case (size)
            ACC_BYTE: result = {{(DATA_W-BYTE_W){sgn & byte_val[BYTE_W-1]}}, byte_val};
            ACC_HALF: result = {{(DATA_W-HALF_W){sgn & half_val[HALF_W-1]}}, half_val};
            default:  result = rotated;
        endcase
    end
endmodule

// File: rtl/lsl_store_lanes.sv
module lsl_store_lanes
    import lsl_fmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  acc_size_e                          size,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]   ofs,
    input  logic [DATA_W-1:0]                  src,
    output logic [DATA_W-1:0]                  wdata,
    output logic [DATA_W/BYTE_W-1:0]           be
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int OFS_W = $clog2(LANES);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            unique case (size)
                ACC_BYTE: begin
                    wdata[k*BYTE_W +: BYTE_W] = src[BYTE_W-1:0];
                    be[k] = (ofs == OFS_W'(k));
                end
                ACC_HALF: begin
                    wdata[k*BYTE_W +: BYTE_W] = src[(k%2)*BYTE_W +: BYTE_W];
                    be[k] = ((ofs >> 1) == OFS_W'(k/2));
                end
                default: begin
                    wdata[k*BYTE_W +: BYTE_W] = src[k*BYTE_W +: BYTE_W];
                    be[k] = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/load_store_lane_fmt.sv
module load_store_lane_fmt
    import lsl_fmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         acc_size,
    input  logic                               acc_signed,
    input  logic                               acc_store,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]   addr_lo,
    input  logic [DATA_W-1:0]                  mem_rdata,
    input  logic [DATA_W-1:0]                  st_src,
    output logic [DATA_W-1:0]                  ld_value,
    output logic [DATA_W-1:0]                  mem_wdata,
    output logic [DATA_W/BYTE_W-1:0]           mem_be
);
    localparam int LANES = DATA_W / BYTE_W;

    acc_size_e          size_in;
    logic [DATA_W-1:0]  ld_comb;
    logic [DATA_W-1:0]  st_comb;
    logic [LANES-1:0]   be_comb;

    acc_size_e          size_q;
    logic               sgn_q;
    logic               store_q;

    assign size_in = acc_size_e'(acc_size);

    lsl_load_align #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_load (
        .size   (size_in),
        .sgn    (acc_signed),
        .ofs    (addr_lo),
        .rdata  (mem_rdata),
        .result (ld_comb)
    );

    lsl_store_lanes #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_store (
        .size   (size_in),
        .ofs    (addr_lo),
        .src    (st_src),
        .wdata  (st_comb),
        .be     (be_comb)
    );

    // Output stage: one register per result, cleared by reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_value  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
            size_q    <= ACC_BYTE;
            sgn_q     <= 1'b0;
            store_q   <= 1'b0;
        end else begin
            ld_value  <= acc_store ? '0 : ld_comb;
            mem_wdata <= acc_store ? st_comb : '0;
            mem_be    <= acc_store ? be_comb : '0;
            size_q    <= size_in;
            sgn_q     <= acc_signed;
            store_q   <= acc_store;
        end
    end

    AST_LOAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !store_q |-> (mem_be == '0 && mem_wdata == '0)); // R9
    AST_STORE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        store_q |-> ld_value == '0); // R9
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_q && size_q == ACC_BYTE) |-> $countones(mem_be) == 1); // R6
    AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (store_q && size_q == ACC_HALF) |-> (mem_be == 4'b0011 || mem_be == 4'b1100)); // R7
    AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (store_q && (size_q == ACC_WORD || size_q == ACC_WIDE)) |-> mem_be == '1); // R8
    AST_UBYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_q && size_q == ACC_BYTE && !sgn_q) |-> ld_value[DATA_W-1:BYTE_W] == '0); // R3
    AST_SBYTE_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_q && size_q == ACC_BYTE && sgn_q) |->
        (ld_value[DATA_W-1:BYTE_W] == '0 || ld_value[DATA_W-1:BYTE_W-1] == '1)); // R5
    AST_BYTE_REPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_q && size_q == ACC_BYTE) |->
        mem_wdata == {LANES{mem_wdata[BYTE_W-1:0]}}); // R6
endmodule

// File: tb/load_store_lane_fmt_tb_top.sv
`timescale 1ns/1ps
module load_store_lane_fmt_tb_top;
    typedef struct packed {
        logic        st;
        logic        sg;
        logic [1:0]  sz;
        logic [1:0]  ad;
        logic [31:0] rd;
        logic [31:0] src;
        logic [31:0] eld;
        logic [31:0] ewd;
        logic [3:0]  ebe;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam logic [31:0] RA = 32'h8C7A_F1E3;
    localparam logic [31:0] RB = 32'h1234_5678;
    localparam logic [31:0] SS = 32'hA5B6_C7D8;

    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,2'b10,2'd0,RA,SS,32'h8C7A_F1E3,32'h0,4'h0,4'd2},  // R2 aligned
        '{1'b0,1'b0,2'b10,2'd1,RA,SS,32'hE38C_7AF1,32'h0,4'h0,4'd2},  // R2
        '{1'b0,1'b0,2'b10,2'd2,RA,SS,32'hF1E3_8C7A,32'h0,4'h0,4'd2},  // R2
        '{1'b0,1'b0,2'b10,2'd3,RA,SS,32'h7AF1_E38C,32'h0,4'h0,4'd2},  // R2
        '{1'b0,1'b0,2'b00,2'd0,RA,SS,32'h0000_00E3,32'h0,4'h0,4'd3},  // R3
        '{1'b0,1'b0,2'b00,2'd2,RA,SS,32'h0000_007A,32'h0,4'h0,4'd3},  // R3
        '{1'b0,1'b1,2'b00,2'd1,RA,SS,32'hFFFF_FFF1,32'h0,4'h0,4'd5},  // R5
        '{1'b0,1'b1,2'b00,2'd3,RB,SS,32'h0000_0012,32'h0,4'h0,4'd5},  // R5 positive
        '{1'b0,1'b0,2'b01,2'd0,RA,SS,32'h0000_F1E3,32'h0,4'h0,4'd4},  // R4
        '{1'b0,1'b0,2'b01,2'd3,RA,SS,32'h0000_8C7A,32'h0,4'h0,4'd4},  // R4 odd
        '{1'b0,1'b1,2'b01,2'd2,RA,SS,32'hFFFF_8C7A,32'h0,4'h0,4'd5},  // R5
        '{1'b0,1'b1,2'b01,2'd1,RA,SS,32'hFFFF_F1E3,32'h0,4'h0,4'd5},  // R5 odd
        '{1'b0,1'b1,2'b01,2'd2,RB,SS,32'h0000_1234,32'h0,4'h0,4'd5},  // R5 positive
        '{1'b0,1'b1,2'b11,2'd1,RA,SS,32'hE38C_7AF1,32'h0,4'h0,4'd10}, // R10
        '{1'b0,1'b1,2'b10,2'd3,RA,SS,32'h7AF1_E38C,32'h0,4'h0,4'd10}, // R10
        '{1'b1,1'b0,2'b00,2'd0,RA,SS,32'h0,32'hD8D8_D8D8,4'b0001,4'd6}, // R6
        '{1'b1,1'b1,2'b00,2'd1,RA,SS,32'h0,32'hD8D8_D8D8,4'b0010,4'd6}, // R6
        '{1'b1,1'b0,2'b00,2'd3,RB,SS,32'h0,32'hD8D8_D8D8,4'b1000,4'd6}, // R6
        '{1'b1,1'b0,2'b01,2'd2,RA,SS,32'h0,32'hC7D8_C7D8,4'b1100,4'd7}, // R7
        '{1'b1,1'b0,2'b01,2'd1,RA,SS,32'h0,32'hC7D8_C7D8,4'b0011,4'd7}, // R7
        '{1'b1,1'b0,2'b10,2'd2,RA,SS,32'h0,32'hA5B6_C7D8,4'b1111,4'd8}, // R8
        '{1'b1,1'b0,2'b11,2'd0,RB,SS,32'h0,32'hA5B6_C7D8,4'b1111,4'd10} // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        acc_signed = 1'b0;
    logic        acc_store = 1'b0;
    logic [1:0]  addr_lo = 2'd0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] st_src = '0;
    logic [31:0] ld_value;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    load_store_lane_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .acc_signed(acc_signed),
        .acc_store(acc_store), .addr_lo(addr_lo), .mem_rdata(mem_rdata),
        .st_src(st_src), .ld_value(ld_value), .mem_wdata(mem_wdata), .mem_be(mem_be)
    );

    task automatic check(input string tag, input logic [31:0] eld,
                         input logic [31:0] ewd, input logic [3:0] ebe);
        n_checks++;
        if (ld_value !== eld || mem_wdata !== ewd || mem_be !== ebe) begin
            n_fail++;
            $display("FAIL %s: ld=%h wd=%h be=%b expected ld=%h wd=%h be=%b",
                     tag, ld_value, mem_wdata, mem_be, eld, ewd, ebe);
        end
    endtask

    task automatic drive(input vec_t v);
        acc_store  = v.st;
        acc_signed = v.sg;
        acc_size   = v.sz;
        addr_lo    = v.ad;
        mem_rdata  = v.rd;
        st_src     = v.src;
    endtask

    initial begin
        // R1: reset state while a store is presented
        drive(VEC[20]);
        repeat (2) @(negedge clk);
        check("R1 reset", 32'h0, 32'h0, 4'h0);
        rst_n = 1'b1;

        // Table walked back to back, loads and stores interleaved by order
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].eld, VEC[i].ewd, VEC[i].ebe);
        end

        // R1: latency, new inputs between edges leave outputs unchanged
        drive(VEC[15]);
        @(negedge clk);
        drive(VEC[4]);
        #1;
        check("R1 latency hold", 32'h0, 32'hD8D8_D8D8, 4'b0001);
        @(negedge clk);
        check("R3 after store", 32'h0000_00E3, 32'h0, 4'h0);

        // R9: store ignores read data
        drive(VEC[18]);
        mem_rdata = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R9 store ignores rdata", 32'h0, 32'hC7D8_C7D8, 4'b1100);

        // R1: reset collides with a word store
        drive(VEC[20]);
        @(negedge clk);
        check("R8 before reset", 32'h0, 32'hA5B6_C7D8, 4'b1111);
        #1 rst_n = 1'b0;
        #0.5;
        check("R1 async clear", 32'h0, 32'h0, 4'h0);
        @(negedge clk);
        check("R1 held in reset", 32'h0, 32'h0, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 resume", 32'h0, 32'hA5B6_C7D8, 4'b1111);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule